// File: doc/BRIEF.md
# S/PDIF Biphase-Mark Audio Transmitter

This block turns a stream of stereo 24-bit audio sample pairs into a single-wire line signal in the consumer digital audio format. A frame holds a left sub-frame (channel A) and then a right sub-frame (channel B). Each sub-frame occupies 32 bit cells. It opens with a 4-cell sync preamble, then carries 24 audio bits sent least-significant first, then four status bits. 192 frames make one block. The preamble of the first left sub-frame of a block marks the block start.

Sample pairs arrive over a valid/ready handshake, each with its own validity and user flag, and are held in a one-deep buffer. A 192-bit channel-status vector supplies one bit per frame. A clock-enable tick at twice the symbol rate paces the line. Each tick emits one half-cell of biphase-mark code. Only the serial data line is driven.

Top module: `spdif_bmc_tx`

## Requirements
- R1: After reset `sdo` is 0 and `smp_ready` is 1, and the first sub-frame sent is channel A of frame 0.
- R2: Every sub-frame lasts exactly 64 ticks. Sub-frames alternate A, B, A, B. The frame number runs 0 to 191 and wraps to 0.
- R3: The preamble is type B (half-cells 11101000) for channel A of frame 0, type M (11100010) for channel A of any other frame, and type W (11100100) for channel B. These patterns are relative to a prior line level of 0 and are inverted when the line was high.
- R4: Sub-frame cells 4 to 27 carry the channel's 24-bit sample, bit 0 first, left sample in channel A and right sample in channel B.
- R5: Cell 28 is the validity bit, cell 29 the user bit, cell 30 the channel-status bit and cell 31 the parity bit. Parity makes cells 4 to 31 hold an even number of ones.
- R6: In cells 4 to 31 the line toggles at the start of every cell.
- R7: In cells 4 to 31 the line toggles at mid-cell exactly when the cell's bit is 1.
- R8: The first half-cell of every preamble differs from the line level before it.
- R9: `smp_ready` is high while the holding buffer is empty and drops in the cycle after a pair is accepted. A pair accepted during frame n is sent in frame n+1 with its own validity and user flags.
- R10: If no pair was accepted by the end of a frame, the next frame repeats the previous samples and user flag, with the validity bit set to 1.
- R11: The channel-status bit sent in both sub-frames of frame n is `chan_status[n]`.
- R12: `sdo` changes only on clock edges where `tick_2x` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_2x | input | 1 | Clock enable at twice the symbol rate; one half-cell per tick |
| smp_valid | input | 1 | Sample pair offered |
| smp_ready | output | 1 | Holding buffer empty, pair will be taken |
| smp_left | input | 24 | Left (channel A) sample |
| smp_right | input | 24 | Right (channel B) sample |
| smp_invalid | input | 1 | Validity bit for the pair (1 = not usable audio) |
| smp_user | input | 1 | User bit for the pair |
| chan_status | input | 192 | Channel-status bit per frame number |
| sdo | output | 1 | Biphase-mark coded serial output |

## Verification
A wrong half-cell or sub-frame counter shows within one sub-frame (64 ticks). Preambles would land off their slots, and the decoded cell-start toggles would vanish mid-word. A frame counter that drifts or wraps wrongly shows up as a misplaced block-start preamble or a channel-status bit from the wrong index, and is seen at frame 192 at the latest. A buffer fault shows in the very next frame, as a decoded sample or validity bit that differs from the pair offered or from the repeat rule.

// File: rtl/spdif_pkg.sv
package spdif_pkg;
  localparam int SMP_W      = 24;
  localparam int PAYLOAD_W  = 28;
  localparam int HALF_CNT   = 64;
  localparam int PRE_HALVES = 8;

  typedef enum logic [1:0] {PRE_BLOCK, PRE_CHA, PRE_CHB} pre_kind_t;

  typedef struct packed {
    logic [SMP_W-1:0] left;
    logic [SMP_W-1:0] right;
    logic             invalid;
    logic             user;
  } pair_t;

  function automatic pre_kind_t pick_pre(input logic block_start, input logic chan_b);
    if (chan_b)           return PRE_CHB;
    else if (block_start) return PRE_BLOCK;
    else                  return PRE_CHA;
  endfunction

  // half-cell levels, earliest first in the MSB, relative to a low line
  function automatic logic [7:0] pre_halves(input pre_kind_t k);
    case (k)
      PRE_BLOCK: return 8'b1110_1000;
      PRE_CHA:   return 8'b1110_0010;
      default:   return 8'b1110_0100;
    endcase
  endfunction

  // payload[0] is cell 4 of the sub-frame
  function automatic logic [PAYLOAD_W-1:0] build_payload(
      input logic [SMP_W-1:0] d, input logic v, input logic u, input logic c);
    logic p;
    p = ^{d, v, u, c};
    return {p, c, u, v, d};
  endfunction
endpackage

// File: rtl/spdif_frame_seq.sv
module spdif_frame_seq #(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [5:0]    half_idx,
  output logic          chan_b,
  output logic [FW-1:0] frame_idx,
  output logic          frame_last
);
  logic sf_last;
  assign sf_last    = tick && (half_idx == 6'(spdif_pkg::HALF_CNT - 1));
  assign frame_last = sf_last && chan_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      half_idx  <= '0;
      chan_b    <= 1'b0;
      frame_idx <= '0;
    end else if (tick) begin
      half_idx <= half_idx + 6'd1;
      if (sf_last) chan_b <= ~chan_b;
      if (frame_last)
        frame_idx <= (frame_idx == FW'(FRAMES - 1)) ? '0 : frame_idx + FW'(1);
    end
  end

  // R2
  frame_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_idx < FW'(FRAMES));
  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_last && frame_idx == FW'(FRAMES - 1) |=> frame_idx == '0);
  // R2
  chan_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sf_last |=> chan_b != $past(chan_b));
endmodule

// File: rtl/spdif_sample_buf.sv
module spdif_sample_buf
  import spdif_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  pair_t in_pair,
  input  logic  load,
  output pair_t cur
);
  pair_t held;
  logic  full;
  logic  accept;

  assign accept   = in_valid && !full;
  assign in_ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      held <= '0;
      cur  <= '{left: '0, right: '0, invalid: 1'b1, user: 1'b0};
    end else begin
      if (accept) held <= in_pair;
      if (load) begin
        if (full) cur <= held;
        else      cur.invalid <= 1'b1;
      end
      if (accept)                full <= 1'b1;
      else if (load)             full <= 1'b0;
    end
  end

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !load |=> !in_ready);
  // R10
  underrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && in_ready |=> cur.invalid);
  // R10
  underrun_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && in_ready |=> cur.left == $past(cur.left) && cur.right == $past(cur.right));
endmodule

// File: rtl/spdif_bmc_coder.sv
module spdif_bmc_coder
  import spdif_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic [5:0]           half_idx,
  input  logic [PAYLOAD_W-1:0] payload,
  input  logic [7:0]           pre,
  output logic                 sdo
);
  logic       ref_q;
  logic       ref_lvl;
  logic       in_pre;
  logic       mid_cell;
  logic [4:0] cell_off;
  logic       cell_bit;
  logic       sdo_nxt;

  assign in_pre   = half_idx < 6'(PRE_HALVES);
  assign mid_cell = half_idx[0];
  assign cell_off = half_idx[5:1] - 5'd4;
  assign cell_bit = in_pre ? 1'b0 : payload[cell_off];
  assign ref_lvl  = (half_idx == '0) ? sdo : ref_q;

  always_comb begin
    if (in_pre)         sdo_nxt = pre[~half_idx[2:0]] ^ ref_lvl;
    else if (!mid_cell) sdo_nxt = ~sdo;
    else                sdo_nxt = sdo ^ cell_bit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sdo   <= 1'b0;
      ref_q <= 1'b0;
    end else if (tick) begin
      sdo <= sdo_nxt;
      if (half_idx == '0) ref_q <= sdo;
    end
  end

  // R6
  cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !in_pre && !mid_cell |=> sdo != $past(sdo));
  // R7
  mid_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !in_pre && mid_cell |=> (sdo != $past(sdo)) == $past(cell_bit));
  // R8
  pre_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && half_idx == '0 |=> sdo != $past(sdo));
  // R5
  even_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick && half_idx == '0 |-> ($countones(payload) % 2) == 0);
  // R12
  tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(sdo));
endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
  import spdif_pkg::*;
#(
  parameter int FRAMES = 192,
  localparam int FW = $clog2(FRAMES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_2x,
  input  logic              smp_valid,
  output logic              smp_ready,
  input  logic [SMP_W-1:0]  smp_left,
  input  logic [SMP_W-1:0]  smp_right,
  input  logic              smp_invalid,
  input  logic              smp_user,
  input  logic [FRAMES-1:0] chan_status,
  output logic              sdo
);
  logic [5:0]           half_idx;
  logic                 chan_b;
  logic [FW-1:0]        frame_idx;
  logic                 frame_last;
  pair_t                in_pair;
  pair_t                cur;
  logic [PAYLOAD_W-1:0] payload;
  logic [7:0]           pre;
  logic                 block_start;

  assign in_pair     = '{left: smp_left, right: smp_right, invalid: smp_invalid, user: smp_user};
  assign block_start = (frame_idx == '0);
  assign payload     = build_payload(chan_b ? cur.right : cur.left, cur.invalid, cur.user,
                                     chan_status[frame_idx]);
  assign pre         = pre_halves(pick_pre(block_start, chan_b));

  spdif_frame_seq #(.FRAMES(FRAMES)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick_2x), .half_idx(half_idx),
    .chan_b(chan_b), .frame_idx(frame_idx), .frame_last(frame_last));

  spdif_sample_buf u_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .in_ready(smp_ready),
    .in_pair(in_pair), .load(frame_last), .cur(cur));

  spdif_bmc_coder u_coder (
    .clk(clk), .rst_n(rst_n), .tick(tick_2x), .half_idx(half_idx),
    .payload(payload), .pre(pre), .sdo(sdo));

  // R9
  cur_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_last |=> $stable(cur));
endmodule

// File: tb/spdif_bmc_tx_tb.sv
module spdif_bmc_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NFR        = 192;
  localparam int RUN_FRAMES = 196;
  localparam int WD_LIMIT   = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick_2x = 1'b0;
  logic           smp_valid = 1'b0;
  logic           smp_ready;
  logic [23:0]    smp_left = '0, smp_right = '0;
  logic           smp_invalid = 1'b0, smp_user = 1'b0;
  logic [NFR-1:0] chan_status;
  logic           sdo;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_bmc_tx u_dut (
    .clk(clk), .rst_n(rst_n), .tick_2x(tick_2x), .smp_valid(smp_valid),
    .smp_ready(smp_ready), .smp_left(smp_left), .smp_right(smp_right),
    .smp_invalid(smp_invalid), .smp_user(smp_user), .chan_status(chan_status),
    .sdo(sdo));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [23:0] gen_l(input int f);
    if (f == 2) return 24'hFFFFFF;
    if (f == 5) return 24'h000000;
    return 24'((f * 32'h0B1D3) + 32'h5A5A5);
  endfunction
  function automatic logic [23:0] gen_r(input int f);
    return ~gen_l(f) ^ 24'(f << 4);
  endfunction
  function automatic bit gives(input int f);  return (f % 7) != 3; endfunction
  function automatic bit gen_v(input int f);  return (f % 5) == 1; endfunction
  function automatic bit gen_u(input int f);  return f[0];          endfunction

  // expected state of the frame being decoded
  logic [23:0] e_l = '0, e_r = '0;
  bit          e_v = 1'b1, e_u = 1'b0;
  bit          given = 1'b0;
  logic [23:0] g_l, g_r;
  bit          g_v, g_u;

  logic [63:0] halves;
  int  hc = 0, fa = 0;
  bit  chb = 1'b0;
  bit  prev_lvl = 1'b0;
  bit  last_sdo = 1'b0;
  bit  drop_next = 1'b0;
  bit  running = 1'b0;

  task automatic finish_subframe();
    logic [7:0]  rel, exp_pre;
    logic [31:0] word;
    bit          tog_ok;
    logic [23:0] exp_d;
    for (int i = 0; i < 8; i++) rel[7-i] = halves[i] ^ prev_lvl;
    exp_pre = chb ? 8'hE4 : ((fa % NFR) == 0 ? 8'hE8 : 8'hE2);
    chk(rel == exp_pre, "R3 preamble", {24'h0, rel}, {24'h0, exp_pre});
    chk(halves[0] != prev_lvl, "R8 preamble entry", {31'h0, halves[0]}, {31'h0, ~prev_lvl});
    tog_ok = 1'b1;
    word = '0;
    for (int b = 4; b < 32; b++) begin
      if (halves[2*b] == halves[2*b-1]) tog_ok = 1'b0;
      word[b] = halves[2*b] ^ halves[2*b+1];
    end
    chk(tog_ok, "R6 cell start toggle", {31'h0, tog_ok}, 32'h1);
    exp_d = chb ? e_r : e_l;
    chk(word[27:4] == exp_d, chb ? "R4 R7 R9 R10 right data" : "R4 R7 R9 R10 left data",
        {8'h0, word[27:4]}, {8'h0, exp_d});
    chk(word[28] == e_v, "R5 R10 validity bit", {31'h0, word[28]}, {31'h0, e_v});
    chk(word[29] == e_u, "R5 R9 user bit", {31'h0, word[29]}, {31'h0, e_u});
    chk(word[30] == chan_status[fa % NFR], "R11 channel status bit",
        {31'h0, word[30]}, {31'h0, chan_status[fa % NFR]});
    chk((^word[31:4]) == 1'b0, "R5 even parity", word, 32'h0);
    prev_lvl = halves[63];
    if (chb) begin
      if (given) begin
        e_l = g_l; e_r = g_r; e_v = g_v; e_u = g_u;
      end else begin
        e_v = 1'b1;
      end
      given = 1'b0;
      fa++;
    end
    chb = ~chb;
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (drop_next) begin
        smp_valid = 1'b0;
        drop_next = 1'b0;
        chk(smp_ready == 1'b0, "R9 ready drops after accept", {31'h0, smp_ready}, 32'h0);
      end
      if (tick_2x) begin
        halves[hc] = sdo;
        if (hc == 0 && !chb && gives(fa)) begin
          chk(smp_ready == 1'b1, "R9 ready while empty", {31'h0, smp_ready}, 32'h1);
          g_l = gen_l(fa); g_r = gen_r(fa); g_v = gen_v(fa); g_u = gen_u(fa);
          smp_left = g_l; smp_right = g_r; smp_invalid = g_v; smp_user = g_u;
          smp_valid = 1'b1;
          given = 1'b1;
          drop_next = 1'b1;
        end
        if (hc == 63) begin
          finish_subframe();
          hc = 0;
        end else begin
          hc++;
        end
      end else begin
        chk(sdo == last_sdo, "R12 no change without tick", {31'h0, sdo}, {31'h0, last_sdo});
      end
      last_sdo = sdo;
      tick_2x = ~tick_2x;
    end
  end

  int cyc = 0;
  bit wd_hit = 1'b0;
  always @(posedge clk) begin
    cyc++;
    if (cyc >= WD_LIMIT) wd_hit = 1'b1;
  end

  initial begin
    for (int i = 0; i < NFR; i++) chan_status[i] = ((i % 3) == 0) ^ (i > 100);
    repeat (4) @(negedge clk);
    chk(sdo == 1'b0, "R1 reset sdo", {31'h0, sdo}, 32'h0);
    chk(smp_ready == 1'b1, "R1 reset ready", {31'h0, smp_ready}, 32'h1);
    rst_n = 1'b1;
    running = 1'b1;
    wait (fa >= RUN_FRAMES || wd_hit);
    // R1 R2: frame 0 decoded first, wrap seen as block preamble at frame 192
    chk(!wd_hit, "R2 run completes", {31'h0, wd_hit}, 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule